// File: doc/BRIEF.md
# Bus Clock and Wait-State Controller

This block sits between an 8-bit CPU and its peripherals. It runs on the master oscillator and produces the CPU system clock at half that rate. It uses the decoded device selects to stall bus cycles that reach slow devices. When a cycle opens on the ROM, the sound chip or the video chip, the block holds the CPU ready line low for a set number of system clock cycles, and the video chip can extend the stall further through its own active-low wait line.

Some peripherals have separate read and write pins instead of a combined read/write signal. For these (video, sound and UART) the block turns the CPU read/write level into an active-low read strobe and an active-low write strobe. Each strobe is driven only while the system clock is high. Address decoding happens upstream. The device selects and the video wait line are taken as synchronous to the master clock.

A system clock cycle is one low phase followed by one high phase, which is two master clock cycles. The selects, the read/write level and the video wait line are sampled at the end of each high phase.

Top module: `bus_wait_ctrl`

## Requirements
- R1: `sys_clk` toggles on every master clock edge, which gives half the master frequency. It starts in its low phase after reset.
- R2: While `rst` is high, `rdy` is 1, `rd_n` is 1, `wr_n` is 1 and `sys_clk` is 0. This holds even when reset arrives in the middle of a stall.
- R3: A fresh cycle is one that begins with `rdy` high. If a fresh cycle selects only the ROM, `rdy` falls at the end of its high phase and stays low for exactly WAIT_ROM (default 1) system clock cycles.
- R4: A fresh cycle that selects the sound chip stalls for WAIT_SOUND (default 2) system clock cycles. One that selects the video chip stalls for WAIT_VIDEO (default 3).
- R5: Cycles that select only the UART, or select no device, never drop `rdy`.
- R6: While the video chip is selected and `video_wait_n` is sampled low, `rdy` stays low, and this can run past the end of the count. `rdy` rises at the end of the first high phase in which the count is spent and `video_wait_n` is high. `video_wait_n` has no effect when the video chip is not selected.
- R7: `rdy` changes only when `sys_clk` falls, so it never changes during a high phase.
- R8: `rd_n` (when `rw`=1) or `wr_n` (when `rw`=0) is low for the whole high phase of every cycle in which video, sound or UART is selected. Both strobes are high during low phases and for cycles that select only the ROM or nothing.
- R9: `rd_n` and `wr_n` are never low at the same time.
- R10: Back-to-back accesses to a slow device are stalled one by one. Each fresh cycle reloads the count.
- R11: If several slow selects are active together, the stall length comes from the highest-priority one, in the order video, then sound, then ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_rom | input | 1 | ROM selected by the address decoder |
| sel_video | input | 1 | Video chip selected |
| sel_sound | input | 1 | Sound chip selected |
| sel_uart | input | 1 | UART selected |
| rw | input | 1 | CPU read/write level, 1 = read |
| video_wait_n | input | 1 | Active-low busy line from the video chip |
| sys_clk | output | 1 | CPU system clock, master divided by two |
| rdy | output | 1 | CPU ready, low stalls the current cycle |
| rd_n | output | 1 | Active-low read strobe for separate-strobe peripherals |
| wr_n | output | 1 | Active-low write strobe for separate-strobe peripherals |

## Verification
The bench sends back-to-back ROM reads. A design that loads the counter only on a rising select would let the second read through with no stall. It holds the video wait line longer than the video count, and a design that ends the stall when the count runs out would raise `rdy` too early. It also holds the wait line for only one cycle, which catches a design that lets the wait line cut the count short. The same held-low wait line is applied during a sound access, where a design that ignores the select would stall too long. Combined selects check the priority order. A reset in the middle of a stall must release `rdy` at once.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    // Decoded device selects, one bit per device.
    typedef struct packed {
        logic rom;
        logic video;
        logic sound;
        logic uart;
    } dev_sel_t;

    // Device whose wait count governs a fresh cycle.
    typedef enum logic [1:0] {
        SLOW_NONE  = 2'd0,
        SLOW_ROM   = 2'd1,
        SLOW_SOUND = 2'd2,
        SLOW_VIDEO = 2'd3
    } slow_dev_e;

    // Registered strobe pair.
    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{rd_n: 1'b1, wr_n: 1'b1};

    // Devices with separate read and write pins.
    localparam dev_sel_t STROBE_DEVS = '{rom: 1'b0, video: 1'b1, sound: 1'b1, uart: 1'b1};

    function automatic slow_dev_e pick_slow(dev_sel_t s);
        if (s.video)      return SLOW_VIDEO;
        else if (s.sound) return SLOW_SOUND;
        else if (s.rom)   return SLOW_ROM;
        else              return SLOW_NONE;
    endfunction

    function automatic logic needs_strobe(dev_sel_t s);
        return |(4'(s) & 4'(STROBE_DEVS));
    endfunction

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bwc_phase_gen.sv
module bwc_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic phase_hi
);

    always_ff @(posedge clk) begin
        if (rst) phase_hi <= 1'b0;
        else     phase_hi <= ~phase_hi;
    end

endmodule

// File: rtl/bwc_wait_timer.sv
module bwc_wait_timer
    import bwc_pkg::*;
#(
    parameter int unsigned WAIT_ROM   = 1,
    parameter int unsigned WAIT_VIDEO = 3,
    parameter int unsigned WAIT_SOUND = 2,
    parameter int unsigned CNT_W      = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     phase_hi,
    input  dev_sel_t sel,
    input  logic     video_wait_n,
    output logic     rdy
);

    localparam logic [CNT_W-1:0] LD_ROM   = CNT_W'(WAIT_ROM);
    localparam logic [CNT_W-1:0] LD_VIDEO = CNT_W'(WAIT_VIDEO);
    localparam logic [CNT_W-1:0] LD_SOUND = CNT_W'(WAIT_SOUND);

    logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
    logic             rdy_q, rdy_d;
    logic             vid_hold;
    slow_dev_e        slow;

    assign slow     = pick_slow(sel);
    assign vid_hold = sel.video && !video_wait_n;

    always_comb begin
        unique case (slow)
            SLOW_VIDEO: load_val = LD_VIDEO;
            SLOW_SOUND: load_val = LD_SOUND;
            SLOW_ROM:   load_val = LD_ROM;
            default:    load_val = '0;
        endcase
    end

    // Updates happen only at the edge that ends a high phase.
    always_comb begin
        cnt_d = cnt_q;
        rdy_d = rdy_q;
        if (phase_hi) begin
            if (rdy_q) begin
                cnt_d = load_val;
                rdy_d = (load_val == '0) && !vid_hold;
            end else begin
                cnt_d = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;
                rdy_d = (cnt_d == '0) && !vid_hold;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rdy_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            rdy_q <= rdy_d;
        end
    end

    assign rdy = rdy_q;

endmodule

// File: rtl/bwc_strobe_gen.sv
module bwc_strobe_gen
    import bwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     phase_hi,
    input  dev_sel_t sel,
    input  logic     rw,
    output strobe_t  strb
);

    strobe_t strb_d;
    logic    hit;

    assign hit = needs_strobe(sel);

    // Load at the edge that opens a high phase, clear at the one that closes it.
    always_comb begin
        strb_d = STROBE_IDLE;
        if (!phase_hi) begin
            strb_d.rd_n = !(hit && rw);
            strb_d.wr_n = !(hit && !rw);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) strb <= STROBE_IDLE;
        else     strb <= strb_d;
    end

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int unsigned WAIT_ROM   = 1,
    parameter int unsigned WAIT_VIDEO = 3,
    parameter int unsigned WAIT_SOUND = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_rom,
    input  logic sel_video,
    input  logic sel_sound,
    input  logic sel_uart,
    input  logic rw,
    input  logic video_wait_n,
    output logic sys_clk,
    output logic rdy,
    output logic rd_n,
    output logic wr_n
);

    localparam int unsigned MAX_WAIT = max_of3(WAIT_ROM, WAIT_VIDEO, WAIT_SOUND);
    localparam int unsigned CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

    dev_sel_t sel;
    strobe_t  strb;
    logic     phase_hi;

    assign sel.rom   = sel_rom;
    assign sel.video = sel_video;
    assign sel.sound = sel_sound;
    assign sel.uart  = sel_uart;

    bwc_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .phase_hi (phase_hi)
    );

    bwc_wait_timer #(
        .WAIT_ROM   (WAIT_ROM),
        .WAIT_VIDEO (WAIT_VIDEO),
        .WAIT_SOUND (WAIT_SOUND),
        .CNT_W      (CNT_W)
    ) u_wait (
        .clk          (clk),
        .rst          (rst),
        .phase_hi     (phase_hi),
        .sel          (sel),
        .video_wait_n (video_wait_n),
        .rdy          (rdy)
    );

    bwc_strobe_gen u_strobe (
        .clk      (clk),
        .rst      (rst),
        .phase_hi (phase_hi),
        .sel      (sel),
        .rw       (rw),
        .strb     (strb)
    );

    assign sys_clk = phase_hi;
    assign rd_n    = strb.rd_n;
    assign wr_n    = strb.wr_n;

endmodule

// File: rtl/bus_wait_ctrl_checker.sv
module bus_wait_ctrl_checker (
    input logic clk,
    input logic rst,
    input logic sel_rom,
    input logic sel_video,
    input logic sel_sound,
    input logic sys_clk,
    input logic rdy,
    input logic rd_n,
    input logic wr_n
);

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (rdy && rd_n && wr_n && !sys_clk));

    assert_clk_toggles_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sys_clk != $past(sys_clk)));

    assert_rdy_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (rdy != $past(rdy)) |-> !sys_clk);

    assert_strobe_in_high_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> sys_clk);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> wr_n);

    assert_stall_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(sel_rom || sel_video || sel_sound));

endmodule

bind bus_wait_ctrl bus_wait_ctrl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_rom   (sel_rom),
    .sel_video (sel_video),
    .sel_sound (sel_sound),
    .sys_clk   (sys_clk),
    .rdy       (rdy),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/bus_wait_ctrl_bench.sv
module bus_wait_ctrl_bench;

    localparam int unsigned BW_ROM   = 1;
    localparam int unsigned BW_VIDEO = 3;
    localparam int unsigned BW_SOUND = 2;

    logic clk = 1'b0;
    logic rst, sel_rom, sel_video, sel_sound, sel_uart, rw, video_wait_n;
    logic sys_clk, rdy, rd_n, wr_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  sclk;
        logic  rdy;
        logic  rd_n;
        logic  wr_n;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    bus_wait_ctrl #(
        .WAIT_ROM   (BW_ROM),
        .WAIT_VIDEO (BW_VIDEO),
        .WAIT_SOUND (BW_SOUND)
    ) u_bus_wait_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sel_rom      (sel_rom),
        .sel_video    (sel_video),
        .sel_sound    (sel_sound),
        .sel_uart     (sel_uart),
        .rw           (rw),
        .video_wait_n (video_wait_n),
        .sys_clk      (sys_clk),
        .rdy          (rdy),
        .rd_n         (rd_n),
        .wr_n         (wr_n)
    );

    // Monitor: pops and compares after each falling master clock edge.
    // The R1 and R7 timing is covered by the sys_clk and rdy field of each item.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({sys_clk, rdy, rd_n, wr_n} !== {e.sclk, e.rdy, e.rd_n, e.wr_n}) begin
                    errors++;
                    $display("FAIL %s: actual clk/rdy/rd_n/wr_n=%b%b%b%b expected=%b%b%b%b",
                             e.tag, sys_clk, rdy, rd_n, wr_n, e.sclk, e.rdy, e.rd_n, e.wr_n);
                end
            end
        end
    end

    function automatic void push(logic sc, logic r, logic rd, logic wr, string tag);
        exp_t e;
        e.sclk = sc; e.rdy = r; e.rd_n = rd; e.wr_n = wr; e.tag = tag;
        sb_q.push_back(e);
    endfunction

    // Driver: one CPU access. Called at a falling edge inside a low phase.
    task automatic run_access(input logic r, input logic v, input logic s, input logic u,
                              input logic rw_i, input int hold, input string tag);
        int  w;
        int  stall;
        logic strobe;
        w      = v ? BW_VIDEO : (s ? BW_SOUND : (r ? BW_ROM : 0));
        stall  = (v && hold > w) ? hold : w;
        strobe = v | s | u;
        for (int j = 0; j <= stall; j++) begin
            sel_rom = r; sel_video = v; sel_sound = s; sel_uart = u; rw = rw_i;
            video_wait_n = (j < hold) ? 1'b0 : 1'b1;
            @(negedge clk);
            push(1'b1, (j == 0), !(strobe && rw_i), !(strobe && !rw_i), tag);
            @(negedge clk);
            push(1'b0, (j < stall) ? 1'b0 : 1'b1, 1'b1, 1'b1, tag);
        end
        sel_rom = 0; sel_video = 0; sel_sound = 0; sel_uart = 0; rw = 1; video_wait_n = 1;
    endtask

    task automatic direct_check(input logic cond, input string tag);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual clk/rdy/rd_n/wr_n=%b%b%b%b expected=0111",
                     tag, sys_clk, rdy, rd_n, wr_n);
        end
    endtask

    initial begin
        rst = 1; sel_rom = 0; sel_video = 0; sel_sound = 0; sel_uart = 0;
        rw = 1; video_wait_n = 1;
        repeat (4) @(negedge clk);
        #2;
        direct_check(!sys_clk && rdy && rd_n && wr_n, "R2 reset");
        @(negedge clk);
        rst = 0;

        run_access(0, 0, 0, 0, 1, 0, "R1/R5 idle");
        run_access(0, 0, 0, 0, 1, 0, "R1/R5 idle");
        run_access(0, 0, 0, 1, 1, 0, "R5/R8 uart read");
        run_access(0, 0, 0, 1, 0, 0, "R8/R9 uart write");
        run_access(1, 0, 0, 0, 1, 0, "R3 rom read");
        run_access(1, 0, 0, 0, 1, 0, "R10 rom back-to-back 1");
        run_access(1, 0, 0, 0, 1, 0, "R10 rom back-to-back 2");
        run_access(0, 0, 1, 0, 0, 0, "R4/R8 sound write");
        run_access(0, 1, 0, 0, 1, 0, "R4/R8 video read");
        run_access(0, 1, 0, 0, 0, 6, "R6 video wait longer than count");
        run_access(0, 1, 0, 0, 1, 1, "R6 video wait shorter than count");
        run_access(0, 0, 1, 0, 1, 4, "R6 wait ignored on sound");
        run_access(0, 0, 0, 0, 1, 3, "R6 wait ignored when idle");
        run_access(1, 1, 0, 0, 1, 0, "R11 video over rom");
        run_access(1, 0, 1, 0, 0, 0, "R11 sound over rom");
        run_access(0, 1, 1, 0, 1, 0, "R11 video over sound");
        run_access(0, 0, 0, 0, 1, 0, "R7 idle after stalls");

        // Reset in the middle of a video stall (R2).
        sel_video = 1; rw = 0;
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        #2;
        direct_check(!sys_clk && rdy && rd_n && wr_n, "R2 reset mid-stall");
        sel_video = 0; rw = 1;
        @(negedge clk);
        rst = 0;
        run_access(1, 0, 0, 0, 1, 0, "R2/R3 rom after reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule